// File: doc/BRIEF.md
# Serial Audio Output Port (Slave Timing)

This block sends stereo audio samples out on one serial data line. The bit clock and the left/right clock both come from outside the block. The block samples both clocks with its own faster system clock. It updates the data line after each falling edge of the bit clock, so a receiver can capture the data on the next rising edge.

Two framings are supported. In I2S framing, a word starts one bit after the left/right clock changes, and the left channel goes out while that clock is low. In right-justified framing, the word ends on the last bit slot of the half-frame, and the left channel goes out while that clock is high. The block cannot know in advance where a right-justified word must start. It therefore counts the length of the half-frame just finished and uses that count. It sends a 16-, 20- or 24-bit word, taken from the top of each input sample, most significant bit first.

Top module: `aud_ser_tx`

## Requirements
- R1: `sdo` changes only after a falling edge of `bclk` has been seen. While `bclk` is high, `sdo` holds its value.
- R2: When `fmt_rj` is 0 (I2S), the bit sampled on the k-th rising edge after a `lrclk` change (k = 2, 3, ...) is word bit k-2, counted from the MSB.
- R3: When `fmt_rj` is 1 (right-justified), the LSB is sampled on the last rising edge before `lrclk` changes. The word's start point is placed using the length of the previous half-frame. A first slot after each `lrclk` change is always low. Leading bits that do not fit after that slot are dropped.
- R4: The left sample goes out while `lrclk` is 0 in I2S and while `lrclk` is 1 in right-justified. The right sample goes out in the other half.
- R5: Every bit slot that carries no word bit is driven low.
- R6: Both samples are captured together from `left_in`/`right_in` on the first rising edge of `bclk` of each left half-frame. Changes to the inputs at any later point in that frame do not reach `sdo`.
- R7: After reset, `sdo` stays low until two left half-frame starts have been seen, that is, one complete frame. Output starts with the left word that begins at the second of these starts.
- R8: `wlen` sets the word length: 0 selects 16 bits, 1 selects 20 bits, and 2 or 3 select 24 bits. The word is always the top bits of the 24-bit sample.
- R9: While reset is held, and right after it is released, `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run at least four times faster than `bclk` |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External left/right clock; it changes on falling edges of `bclk` |
| fmt_rj | input | 1 | Framing select: 0 = I2S, 1 = right-justified |
| wlen | input | 2 | Word length code (see R8) |
| left_in | input | 24 | Left channel sample |
| right_in | input | 24 | Right channel sample |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the block with its default parameters: 24-bit samples and a 6-bit slot counter. Half-frames of up to 63 bit clocks can therefore be used. The bench sweeps both framings, all four word-length codes, and half-frame lengths of 16, 24, 25 and 32 bit clocks. These lengths cover words that are truncated, words that exactly fill the half-frame, an odd-length half-frame, and words with padding on both sides. It drives junk onto the sample inputs in the middle of each frame, and it begins every run with a partial half-frame so that the start-up silence is exercised.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int DW = 24,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          fmt_rj,
  input  logic [1:0]    wlen,
  input  logic [DW-1:0] left_in,
  input  logic [DW-1:0] right_in,
  output logic          sdo
);

  logic          bclk_q, lr_r, lr_vld, pend;
  logic [1:0]    fcnt;
  logic [CW-1:0] pos, hl, pos_inc, pos_nxt, hl_nxt;
  logic [DW-1:0] smp_l, smp_r;
  logic          bit_nxt;

  wire rise     = bclk & ~bclk_q;
  wire fall     = ~bclk & bclk_q;
  wire lr_edge  = rise & lr_vld & (lrclk != lr_r);
  wire to_left  = fmt_rj ? lrclk : ~lrclk;
  wire cur_left = fmt_rj ? lr_r : ~lr_r;
  wire en       = (fcnt == 2'd2);

  assign pos_inc = (pos == '1) ? pos : pos + 1'b1;
  assign pos_nxt = pend ? '0 : pos_inc;
  assign hl_nxt  = pend ? pos_inc : hl;

  always_comb begin
    int q, l, w, off;
    logic [DW-1:0] sel, sh;
    q = int'(pos_nxt);
    l = int'(hl_nxt);
    case (wlen)
      2'd0:    w = DW - 8;
      2'd1:    w = DW - 4;
      default: w = DW;
    endcase
    off = fmt_rj ? (q + w + 1 - l) : q;
    sel = cur_left ? smp_l : smp_r;
    sh  = sel << off;
    bit_nxt = (off >= 0 && off < w) ? sh[DW-1] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      lr_r   <= 1'b0;
      lr_vld <= 1'b0;
      pend   <= 1'b0;
      fcnt   <= '0;
      pos    <= '0;
      hl     <= '0;
      smp_l  <= '0;
      smp_r  <= '0;
      sdo    <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (rise) begin
        lr_r   <= lrclk;
        lr_vld <= 1'b1;
        if (lr_edge) begin
          pend <= 1'b1;
          if (to_left) begin
            smp_l <= left_in;
            smp_r <= right_in;
            if (fcnt != 2'd2) fcnt <= fcnt + 1'b1;
          end
        end
      end
      if (fall) begin
        pend <= 1'b0;
        pos  <= pos_nxt;
        hl   <= hl_nxt;
        sdo  <= en ? bit_nxt : 1'b0;
      end
    end
  end

  a_r1_edge_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sdo)) |-> ($past(bclk_q) && !$past(bclk)));

  a_r6_pair_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$stable(smp_l) || !$stable(smp_r))) |-> ($past(bclk) && !$past(bclk_q)));

  a_r3_len_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(hl)) |-> ($past(bclk_q) && !$past(bclk)));

  a_r4_lr_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(lr_r)) |-> ($past(bclk) && !$past(bclk_q)));

  a_r7_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fcnt) == 2'd2) |-> (fcnt == 2'd2));

endmodule

// File: tb/tb_aud_ser_tx.sv
`timescale 1ns/1ps
module tb_aud_ser_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        fmt_rj = 1'b0;
  logic [1:0]  wlen = 2'd2;
  logic [23:0] left_in = '0;
  logic [23:0] right_in = '0;
  logic        sdo;

  int nvec = 0;
  int nerr = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic s_lo, s_hi;

  always #2.5 clk = ~clk;

  aud_ser_tx dut (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .fmt_rj(fmt_rj),
    .wlen(wlen), .left_in(left_in), .right_in(right_in), .sdo(sdo)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0b exp=%0b rj=%0b wlen=%0d t=%0t", tag, act, exp, fmt_rj, wlen, $time);
    end
  endtask

  function automatic logic [23:0] nxt_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:8];
  endfunction

  function automatic int word_len(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic int offset_of(input int q, input int len);
    int w;
    w = word_len(wlen);
    return fmt_rj ? (q + w + 1 - len) : q;
  endfunction

  task automatic tick(input logic lv);
    bclk = 1'b0;
    lrclk = lv;
    repeat (2) @(negedge clk);
    s_lo = sdo;
    bclk = 1'b1;
    repeat (2) @(negedge clk);
    s_hi = sdo;
  endtask

  task automatic run_cfg(input logic rj, input logic [1:0] wl, input int len);
    logic lv_left;
    logic [23:0] cl, cr, pr;
    lv_left = rj;
    @(negedge clk);
    rst = 1'b1; fmt_rj = rj; wlen = wl; bclk = 1'b1; lrclk = ~lv_left;
    repeat (4) @(negedge clk);
    chk(sdo, 1'b0, "R9 in reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdo, 1'b0, "R9 after reset");
    for (int k = 0; k < 5; k++) begin
      tick(~lv_left);
      chk(s_lo, 1'b0, "R7 pre-roll");
    end
    pr = '0; cl = '0; cr = '0;
    for (int f = 0; f < 4; f++) begin
      pr = cr;
      cl = nxt_rand();
      cr = nxt_rand();
      for (int h = 0; h < 2; h++) begin
        for (int k = 0; k < len; k++) begin
          logic lv, exp_b, qleft, on;
          logic [23:0] smp;
          int q, qf, off;
          lv = (h == 0) ? lv_left : ~lv_left;
          if (h == 0 && k == 0) begin left_in = cl; right_in = cr; end
          if (h == 1 && k == len / 2) begin left_in = ~cl; right_in = ~cr; end
          tick(lv);
          if (k == 0) begin
            q = len - 1;
            qleft = (h == 1);
            qf = (h == 1) ? f : f - 1;
            smp = (h == 1) ? cl : pr;
          end else begin
            q = k - 1;
            qleft = (h == 0);
            qf = f;
            smp = (h == 0) ? cl : cr;
          end
          off = offset_of(q, len);
          on = (off >= 0 && off < word_len(wl));
          exp_b = (qf >= 1 && on) ? smp[23 - (on ? off : 0)] : 1'b0;
          if (qf < 1) chk(s_lo, exp_b, "R7 silent before full frame");
          else if (!on) chk(s_lo, exp_b, "R5 padding slot");
          else if (!qleft) chk(s_lo, exp_b, "R6 R4 R8 right word");
          else if (rj) chk(s_lo, exp_b, "R3 R4 R8 left word");
          else chk(s_lo, exp_b, "R2 R4 R8 left word");
          chk(s_hi, s_lo, "R1 held while bclk high");
        end
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int wl = 0; wl < 4; wl++) begin
        run_cfg(m[0], 2'(wl), 16);
        run_cfg(m[0], 2'(wl), 24);
        run_cfg(m[0], 2'(wl), 25);
        run_cfg(m[0], 2'(wl), 32);
      end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule